// File: doc/BRIEF.md
# Flash Program Engine with Data Polling

This block carries out one byte or word program operation in a flash device model. A command decoder upstream recognises the unlock and set-up writes. It then raises `prog_arm`, which marks the next bus write cycle as the data cycle of a program command. The engine treats chip enable and write enable together as a single write strobe. It captures the target location when the strobe opens and the data when it closes. The close of the strobe also starts an internal program phase that lasts a fixed number of clock cycles.

While the phase runs, every read returns a status word. Its bit 7 is the complement of bit 7 of the data being programmed, which lets software poll for completion. At the end of the phase the engine writes the array once, at the captured location. The written value is the old content ANDed with the new data, so programming can clear bits but never set them. The engine then goes back to plain array reads at the address on the bus.

Top module: `flash_prog_engine`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0 and `rd_data` equals the array word at the bus address `addr`.
- R2: The target location is captured in the first clock cycle in which `ce_n` and `we_n` are both low. That is the falling edge of whichever of the two falls later. Address changes later in the same strobe have no effect.
- R3: The program data is the `wdata` value present in the last cycle in which both strobes are low. The rising edge of whichever strobe rises first starts the operation, but only if `prog_arm` was 1 in the cycle the strobe opened.
- R4: `busy` rises in the cycle after the strobe closes and stays high for exactly `PROG_CYCLES` clock cycles.
- R5: While `busy` is high, `rd_data` at any bus address has bit 7 equal to the inverse of the programmed data's bit 7, and all other bits are 0.
- R6: The array is written exactly once per operation, in the last busy cycle, at the captured location. The value written is the old word AND the program data, so no 0 bit becomes 1.
- R7: After `busy` falls, `rd_data` again follows the array at the current bus address. A read at the programmed location then shows bit 7 equal to the programmed bit 7.
- R8: Write strobes issued while `busy` is high are ignored. They change neither the target, the data, nor the number of array writes.
- R9: A write strobe with `prog_arm` low starts no operation and writes nothing.
- R10: An asynchronous reset during the program phase drops `busy` at once and performs no array write.
- R11: Operations may target any addresses in any order. Widely separated addresses programmed in descending order each receive their own AND result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| prog_arm | input | 1 | From command decoder: next write cycle is program data |
| addr | input | ADDR_W | Bus address |
| wdata | input | DATA_W | Bus write data |
| busy | output | 1 | Program phase in progress |
| rd_data | output | DATA_W | Read data: array word, or status word while busy |
| arr_addr | output | ADDR_W | Array address: captured target while busy, otherwise bus address |
| arr_rdata | input | DATA_W | Array word at `arr_addr`, combinational |
| arr_we | output | 1 | Array write strobe, one cycle |
| arr_wdata | output | DATA_W | Array write value |

## Verification
The assertions assume that `ce_n`, `we_n`, `addr` and `wdata` are synchronous to `clk` and are sampled at the rising edge. They also assume that `arr_rdata` is a combinational read of the word at `arr_addr`, so the AND check at commit compares against the real old content. The bench changes every bus input on the falling clock edge and models the array as a zero-latency read with a write on the rising edge. Strobes that overlap the busy phase are opened and closed well inside that phase.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [1:0] {
    STROBE_IDLE  = 2'b00,
    STROBE_OPEN  = 2'b01,
    STROBE_HELD  = 2'b10,
    STROBE_CLOSE = 2'b11
  } strobe_phase_e;

  localparam int unsigned POLL_BIT = 7;

endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge
  import flash_prog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_act,
  output logic wr_open,
  output logic wr_close
);

  logic          act_q;
  logic          act_d;
  strobe_phase_e phase;

  assign act_d  = ~ce_n & ~we_n;
  assign wr_act = act_d;

  always_comb begin
    case ({act_q, act_d})
      2'b01:   phase = STROBE_OPEN;
      2'b11:   phase = STROBE_HELD;
      2'b10:   phase = STROBE_CLOSE;
      default: phase = STROBE_IDLE;
    endcase
  end

  assign wr_open  = (phase == STROBE_OPEN);
  assign wr_close = (phase == STROBE_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

endmodule

// File: rtl/flash_prog_latch.sv
module flash_prog_latch #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic              wr_open,
  input  logic              wr_close,
  input  logic              busy,
  input  logic              prog_arm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              launch
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              pend_q, pend_d;
  logic              addr_en, data_en;

  assign addr_en = wr_open & ~busy;
  assign data_en = wr_act  & ~busy;
  assign launch  = wr_close & pend_q & ~busy;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    pend_d = pend_q;
    if (addr_en) begin
      addr_d = addr;
      pend_d = prog_arm;
    end
    if (data_en) data_d = wdata;
    if (wr_close) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      pend_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      pend_q <= pend_d;
    end
  end

  assign tgt_addr = addr_q;
  assign tgt_data = data_q;

  // R8
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic done
);

  localparam int unsigned CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (launch && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_zero) busy_d = 1'b0;
      else          cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q & cnt_zero;

  // Independent cycle count for checking the phase length.
  logic [31:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len_q <= '0;
    else if (launch) run_len_q <= 32'd1;
    else if (busy_q) run_len_q <= run_len_q + 32'd1;
  end

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !busy_q) |=> busy_q);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len_q == PROG_CYCLES));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

endmodule

// File: rtl/flash_poll_mux.sv
module flash_poll_mux
  import flash_prog_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              busy,
  input  logic              prog_bit,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word           = '0;
    status_word[POLL_BIT] = ~prog_bit;
  end

  assign rd_data = busy ? status_word : arr_rdata;

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_prog_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              prog_arm,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_we,
  output logic [DATA_W-1:0] arr_wdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              wr_act, wr_open, wr_close;
  logic              launch, done;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  flash_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .wr_act   (wr_act),
    .wr_open  (wr_open),
    .wr_close (wr_close)
  );

  flash_prog_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_act   (wr_act),
    .wr_open  (wr_open),
    .wr_close (wr_close),
    .busy     (busy),
    .prog_arm (prog_arm),
    .addr     (addr),
    .wdata    (wdata),
    .tgt_addr (tgt_addr),
    .tgt_data (tgt_data),
    .launch   (launch)
  );

  flash_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .launch (launch),
    .busy   (busy),
    .done   (done)
  );

  flash_poll_mux #(.DATA_W(DATA_W)) u_poll (
    .busy      (busy),
    .prog_bit  (tgt_data[POLL_BIT]),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data)
  );

  assign arr_addr  = busy ? tgt_addr : addr;
  assign arr_we    = done;
  assign arr_wdata = arr_rdata & tgt_data;

  // R6
  no_set_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> ((arr_wdata & ~arr_rdata) == '0));

  // R6
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_we |-> (busy && arr_addr == tgt_addr));

  // R5
  poll_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> ($countones(rd_data) <= 1));

endmodule

// File: tb/flash_prog_engine_tb.sv
module flash_prog_engine_tb;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PC = 12;

  logic          clk = 1'b0;
  logic          rst_n, ce_n, we_n, prog_arm;
  logic [AW-1:0] addr, arr_addr;
  logic [DW-1:0] wdata, rd_data, arr_rdata, arr_wdata;
  logic          busy, arr_we;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int            wr_count = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  flash_prog_engine #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .prog_arm(prog_arm),
    .addr(addr), .wdata(wdata), .busy(busy), .rd_data(rd_data),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_we(arr_we),
    .arr_wdata(arr_wdata)
  );

  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic arm, input int hold);
    @(negedge clk);
    addr = a; wdata = d; prog_arm = arm; ce_n = 1'b0; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; prog_arm = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
  endtask

  task automatic t_reset();
    addr = 8'h21; #1;
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(arr_we == 1'b0, "R1 arr_we", arr_we, 0);
    check(rd_data == mem[8'h21], "R1 rd_data", rd_data, mem[8'h21]);
  endtask

  task automatic t_basic();
    logic [DW-1:0] old, nd, exp;
    int n, wc;
    old = mem[8'h40]; nd = 16'h3C5A; exp = old & nd; wc = wr_count;
    bus_write(8'h40, nd, 1'b1, 2);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (n == 1) begin
        #1 check(rd_data == 16'h0080, "R5 status at target", rd_data, 16'h0080);
      end
      if (n == 2) begin
        addr = 8'h07;
        #1 check(rd_data == 16'h0080, "R5 status elsewhere", rd_data, 16'h0080);
      end
    end
    check(n == PC, "R4 busy length", n, PC);
    check(mem[8'h40] == exp, "R6 AND result", mem[8'h40], exp);
    check(wr_count == wc + 1, "R6 single write", wr_count, wc + 1);
    addr = 8'h40; #1;
    check(rd_data[7] == nd[7], "R7 bit7 after done", rd_data[7], nd[7]);
    check(rd_data == exp, "R7 read programmed", rd_data, exp);
    addr = 8'h07; #1;
    check(rd_data == mem[8'h07], "R7 read released", rd_data, mem[8'h07]);
  endtask

  task automatic t_edge_order();
    logic [DW-1:0] exp, o1, o3;
    int n;
    exp = mem[8'h52] & 16'h0F81;
    o1 = mem[8'h51]; o3 = mem[8'h53];
    @(negedge clk); addr = 8'h51; wdata = 16'h1111; prog_arm = 1'b1; ce_n = 1'b0;
    @(negedge clk); addr = 8'h52; we_n = 1'b0;
    @(negedge clk); addr = 8'h53; wdata = 16'h2222; prog_arm = 1'b0;
    @(negedge clk); wdata = 16'h0F81;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1;
    wait_idle(n);
    check(mem[8'h52] == exp, "R2 later fall address / R3 last data", mem[8'h52], exp);
    check(mem[8'h51] == o1 && mem[8'h53] == o3, "R2 other addresses kept",
          mem[8'h53], o3);
  endtask

  task automatic t_ignore_busy();
    logic [DW-1:0] expa, oldb;
    int n, wc;
    expa = mem[8'h60] & 16'h00FF; oldb = mem[8'h61]; wc = wr_count;
    bus_write(8'h60, 16'h00FF, 1'b1, 1);
    repeat (2) @(negedge clk);
    bus_write(8'h61, 16'h0000, 1'b1, 2);
    @(negedge clk); #1;
    check(busy == 1'b1, "R8 still busy", busy, 1);
    check(rd_data == 16'h0000, "R8 status keeps first data", rd_data, 16'h0000);
    wait_idle(n);
    repeat (3) @(negedge clk);
    check(wr_count == wc + 1, "R8 no extra write", wr_count, wc + 1);
    check(mem[8'h60] == expa, "R8 first program", mem[8'h60], expa);
    check(mem[8'h61] == oldb, "R8 ignored target", mem[8'h61], oldb);
  endtask

  task automatic t_no_arm();
    logic [DW-1:0] old;
    int wc;
    old = mem[8'h70]; wc = wr_count;
    bus_write(8'h70, 16'h0000, 1'b0, 2);
    repeat (PC + 4) @(negedge clk);
    check(busy == 1'b0, "R9 no busy", busy, 0);
    check(wr_count == wc, "R9 no write", wr_count, wc);
    addr = 8'h70; #1;
    check(rd_data == old, "R9 data kept", rd_data, old);
  endtask

  task automatic t_abort();
    logic [DW-1:0] old;
    int wc;
    old = mem[8'h80]; wc = wr_count;
    bus_write(8'h80, 16'h0000, 1'b1, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b0; #1;
    check(busy == 1'b0, "R10 busy drops", busy, 0);
    check(arr_we == 1'b0, "R10 no strobe", arr_we, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (PC + 4) @(negedge clk);
    check(wr_count == wc, "R10 no write", wr_count, wc);
    check(mem[8'h80] == old, "R10 word kept", mem[8'h80], old);
  endtask

  task automatic t_cross();
    logic [DW-1:0] ehi, elo;
    int n;
    ehi = mem[8'hF0] & 16'hAAAA; elo = mem[8'h03] & 16'h5555;
    bus_write(8'hF0, 16'hAAAA, 1'b1, 1);
    wait_idle(n);
    bus_write(8'h03, 16'h5555, 1'b1, 1);
    wait_idle(n);
    check(mem[8'hF0] == ehi, "R11 high address", mem[8'hF0], ehi);
    check(mem[8'h03] == elo, "R11 low address", mem[8'h03], elo);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 16'(i * 16'h0137) ^ 16'hC3F9;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; prog_arm = 1'b0;
    addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_edge_order();
    t_ignore_busy();
    t_no_arm();
    t_abort();
    t_cross();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

endmodule